// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This unit settles branches and jumps while they sit in the decode stage of a five-stage in-order pipeline. Each cycle it takes the decoded branch kind, the first source operand, the sign-extended word offset and the branch's own sequential address (its PC+4). It tests the operand against zero, adds the offset to form the target and drives the select of the fetch PC multiplexer. Because both the zero test and the target adder sit in decode, a taken branch costs a single lost fetch slot.

A build parameter picks what happens to the instruction fetched behind a taken branch. In squash mode the pipeline predicts not-taken, so fetch runs on sequentially, and a taken result raises a flush that turns the fetch/decode register into a bubble. In delay-slot mode that instruction is part of the program and always runs, and the fetch after it comes from the target. While the decode stage is stalled, or holds no valid instruction, the unit issues neither a redirect nor a flush.

Top module: `brz_unit`

## Requirements
- R1: With kind code 2'b01 (branch if zero), a valid unstalled instruction redirects (pc_sel_o=1) exactly when rs1_val_i is zero.
- R2: With kind code 2'b10 (branch if not zero), a valid unstalled instruction redirects exactly when rs1_val_i is non-zero.
- R3: With kind code 2'b11 (jump), a valid unstalled instruction always redirects.
- R4: target_o equals seq_pc_i plus imm_i shifted left by two, modulo 2^XLEN, in every cycle.
- R5: next_pc_o equals target_o when pc_sel_o is 1 and fetch_seq_pc_i otherwise.
- R6: With DELAY_SLOT=0, flush_o is 1 in exactly the cycles where pc_sel_o is 1.
- R7: With DELAY_SLOT=1, flush_o stays 0 and a taken branch still sets pc_sel_o, so the next fetch after the slot instruction comes from the target.
- R8: When stall_i is 1 or dec_valid_i is 0, pc_sel_o and flush_o are both 0 and next_pc_o is fetch_seq_pc_i.
- R9: Kind code 2'b00 (no branch) never redirects or flushes, whatever rs1_val_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock used by the built-in checks |
| rst_ni | input | 1 | Active-low asynchronous reset, gates the checks |
| dec_valid_i | input | 1 | Decode stage holds a valid instruction |
| stall_i | input | 1 | Decode stage is held this cycle |
| br_kind_i | input | 2 | 00 none, 01 branch if zero, 10 branch if not zero, 11 jump |
| rs1_val_i | input | XLEN | First source operand value |
| imm_i | input | XLEN | Sign-extended word offset |
| seq_pc_i | input | XLEN | Address after the branch (its PC+4) |
| fetch_seq_pc_i | input | XLEN | Sequential next fetch address |
| pc_sel_o | output | 1 | 1 selects the branch target for the next fetch |
| target_o | output | XLEN | Computed branch target |
| next_pc_o | output | XLEN | Next fetch address |
| flush_o | output | 1 | Turn the fetch/decode register into a bubble |

## Verification
The clocked checks take for granted that every input carries a defined value once reset is released and that the kind field only ever holds the four listed codes, all of which are legal. The stimulus is changed just after each rising edge and compared at the falling edge, and it walks through zero and non-zero operands, positive and negative offsets, stalls and idle cycles, so no input is undefined at a sampling edge. A behavioural model in the bench tracks a fetch address per mode and compares the whole next-PC sequence cycle by cycle.

// File: rtl/brz_pkg.sv
package brz_pkg;
  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_EQZ  = 2'b01,
    BR_NEZ  = 2'b10,
    BR_JMP  = 2'b11
  } br_kind_e;
endpackage

// File: rtl/brz_cond.sv
module brz_cond
  import brz_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_kind_e            kind_i,
  input  logic [XLEN-1:0]     rs1_i,
  output logic                taken_o
);
  logic is_zero;

  assign is_zero = ~|rs1_i;

  always_comb begin
    unique case (kind_i)
      BR_EQZ:  taken_o = is_zero;
      BR_NEZ:  taken_o = ~is_zero;
      BR_JMP:  taken_o = 1'b1;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/brz_target.sv
module brz_target #(
  parameter int XLEN      = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [XLEN-1:0] seq_pc_i,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] target_o
);
  localparam int OFF_SHIFT = $clog2(WORD_BYTES);

  logic [XLEN-1:0] byte_off;

  assign byte_off = imm_i << OFF_SHIFT;
  assign target_o = seq_pc_i + byte_off;
endmodule

// File: rtl/brz_redirect.sv
module brz_redirect #(
  parameter bit DELAY_SLOT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic stall_i,
  input  logic taken_i,
  output logic pc_sel_o,
  output logic flush_o
);
  logic resolve_en;

  // resolution is held while decode is stalled
  assign resolve_en = valid_i & ~stall_i;
  assign pc_sel_o   = resolve_en & taken_i;

  generate
    if (DELAY_SLOT) begin : g_slot
      assign flush_o = 1'b0;
      // R7
      slot_never_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flush_o);
    end else begin : g_squash
      assign flush_o = pc_sel_o;
      // R6
      squash_on_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !stall_i && taken_i) |-> flush_o);
    end
  endgenerate

  // R8
  hold_no_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i || !valid_i) |-> (!pc_sel_o && !flush_o));
endmodule

// File: rtl/brz_unit.sv
module brz_unit
  import brz_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int WORD_BYTES = 4,
  parameter bit DELAY_SLOT = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dec_valid_i,
  input  logic            stall_i,
  input  logic [1:0]      br_kind_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [XLEN-1:0] seq_pc_i,
  input  logic [XLEN-1:0] fetch_seq_pc_i,
  output logic            pc_sel_o,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic            flush_o
);
  br_kind_e kind;
  logic     taken;

  assign kind = br_kind_e'(br_kind_i);

  brz_cond #(.XLEN(XLEN)) u_cond (
    .kind_i  (kind),
    .rs1_i   (rs1_val_i),
    .taken_o (taken)
  );

  brz_target #(.XLEN(XLEN), .WORD_BYTES(WORD_BYTES)) u_target (
    .seq_pc_i (seq_pc_i),
    .imm_i    (imm_i),
    .target_o (target_o)
  );

  brz_redirect #(.DELAY_SLOT(DELAY_SLOT)) u_redirect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (dec_valid_i),
    .stall_i  (stall_i),
    .taken_i  (taken),
    .pc_sel_o (pc_sel_o),
    .flush_o  (flush_o)
  );

  assign next_pc_o = pc_sel_o ? target_o : fetch_seq_pc_i;

  // R1
  eqz_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && !stall_i && br_kind_i == 2'b01) |-> (pc_sel_o == (rs1_val_i == '0)));
  // R2
  nez_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && !stall_i && br_kind_i == 2'b10) |-> (pc_sel_o == (rs1_val_i != '0)));
  // R3
  jump_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && !stall_i && br_kind_i == 2'b11) |-> pc_sel_o);
  // R9
  none_no_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_kind_i == 2'b00) |-> (!pc_sel_o && !flush_o));
  // R5
  seq_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_sel_o |-> (next_pc_o == fetch_seq_pc_i));
endmodule

// File: tb/brz_unit_tb.sv
module brz_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dec_valid, stall;
  logic [1:0] kind;
  logic [XLEN-1:0] rs1, imm, seq_pc;
  logic [XLEN-1:0] fpc_sq, fpc_ds;
  logic sel_sq, sel_ds, fl_sq, fl_ds;
  logic [XLEN-1:0] tgt_sq, tgt_ds, npc_sq, npc_ds;

  int total = 0;
  int bad = 0;
  logic [XLEN-1:0] pc_sq_m, pc_ds_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  brz_unit #(.XLEN(XLEN), .DELAY_SLOT(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .dec_valid_i(dec_valid), .stall_i(stall),
    .br_kind_i(kind), .rs1_val_i(rs1), .imm_i(imm), .seq_pc_i(seq_pc),
    .fetch_seq_pc_i(fpc_sq), .pc_sel_o(sel_sq), .target_o(tgt_sq),
    .next_pc_o(npc_sq), .flush_o(fl_sq));

  brz_unit #(.XLEN(XLEN), .DELAY_SLOT(1'b1)) u_dut_ds (
    .clk_i(clk), .rst_ni(rst_ni), .dec_valid_i(dec_valid), .stall_i(stall),
    .br_kind_i(kind), .rs1_val_i(rs1), .imm_i(imm), .seq_pc_i(seq_pc),
    .fetch_seq_pc_i(fpc_ds), .pc_sel_o(sel_ds), .target_o(tgt_ds),
    .next_pc_o(npc_ds), .flush_o(fl_ds));

  task automatic check(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // apply one decode cycle, compare both modes against the model
  task automatic step(string tag, bit v, bit s, logic [1:0] k,
                      logic [XLEN-1:0] r, logic [XLEN-1:0] i, logic [XLEN-1:0] sp);
    bit tk;
    logic [XLEN-1:0] exp_t;
    @(posedge clk); #1;
    dec_valid = v; stall = s; kind = k; rs1 = r; imm = i; seq_pc = sp;
    fpc_sq = pc_sq_m + 4; fpc_ds = pc_ds_m + 4;
    @(negedge clk);
    tk = 1'b0;
    if (v && !s) begin
      if (k == 2'b11) tk = 1'b1;
      else if (k == 2'b01) tk = (r == 0);
      else if (k == 2'b10) tk = (r != 0);
    end
    exp_t = sp + i * 4;
    check(tag, {31'd0, sel_sq}, {31'd0, tk});
    check(tag, {31'd0, sel_ds}, {31'd0, tk});
    check("R4", tgt_sq, exp_t);
    check("R4", tgt_ds, exp_t);
    check("R6", {31'd0, fl_sq}, {31'd0, tk});
    check("R7", {31'd0, fl_ds}, 32'd0);
    pc_sq_m = tk ? exp_t : pc_sq_m + 4;
    pc_ds_m = tk ? exp_t : pc_ds_m + 4;
    check("R5", npc_sq, pc_sq_m);
    check("R5", npc_ds, pc_ds_m);
  endtask

  initial begin
    dec_valid = 1'b0; stall = 1'b0; kind = 2'b00; rs1 = '0; imm = '0;
    seq_pc = 32'h100; pc_sq_m = 32'h1000; pc_ds_m = 32'h2000;
    fpc_sq = pc_sq_m + 4; fpc_ds = pc_ds_m + 4;
    #(CLK_PERIOD*2 + 2);
    // reset state, R8: nothing valid -> no redirect
    check("R8", {31'd0, sel_sq}, 32'd0);
    check("R8", {31'd0, fl_sq}, 32'd0);
    check("R8", npc_ds, fpc_ds);
    rst_ni = 1'b1;

    step("R1", 1, 0, 2'b01, 32'd0, 32'd5, 32'h104);
    step("R1", 1, 0, 2'b01, 32'd7, 32'd5, 32'h204);
    step("R2", 1, 0, 2'b10, 32'h8000_0000, 32'hFFFF_FFFC, 32'h304);
    step("R2", 1, 0, 2'b10, 32'd0, 32'd3, 32'h404);
    step("R3", 1, 0, 2'b11, 32'd0, 32'h10, 32'h504);
    step("R3", 1, 0, 2'b11, 32'h1, 32'hFFFF_FFFF, 32'h0);
    step("R9", 1, 0, 2'b00, 32'd0, 32'd9, 32'h604);
    step("R9", 1, 0, 2'b00, 32'd1, 32'd9, 32'h608);
    step("R8", 1, 1, 2'b11, 32'd0, 32'd2, 32'h704);
    step("R8", 1, 1, 2'b01, 32'd0, 32'd2, 32'h708);
    step("R8", 0, 0, 2'b11, 32'd0, 32'd2, 32'h70C);
    step("R3", 1, 0, 2'b11, 32'd0, 32'd2, 32'h70C);
    step("R7", 1, 0, 2'b01, 32'd0, 32'h3FFF_FFFF, 32'hFFFF_FFF0);

    for (int n = 0; n < 400; n++) begin
      logic [1:0] k;
      logic [XLEN-1:0] r;
      k = 2'($urandom);
      r = ($urandom % 3 == 0) ? '0 : $urandom;
      step("R5", ($urandom % 8) != 0, ($urandom % 8) == 0, k, r, $urandom, $urandom);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule